// File: doc/BRIEF.md
# Multi-Mode Windowed Watchdog Timer

This block supervises a host processor. A free-running clock-enable tick, nominally 1 kHz, advances a counter. The host restarts that counter with a one-cycle trigger strobe. A configuration write selects one of three modes and a 3-bit period code. The period in ticks is `BASE_TICKS << code`, so the default `BASE_TICKS = 4` gives 4 ms for code 0 up to 512 ms for code 7.

Window mode rejects a trigger that comes too early and also rejects a missing trigger. Each case produces a system reset request. Timeout mode accepts a trigger at any time. When the counter overflows, it first sets the cyclic interrupt. It escalates to a reset request only when that interrupt is still pending. Off mode is quiet. An external off pin can force Off mode. A pending interrupt re-enables the watchdog by itself.

Supply monitoring, the oscillator and the stretching of the reset pulse belong to neighbouring logic.

Top module: `mm_watchdog`

## Requirements
- R1: After `rst_n` is released, the stored mode is Off, the stored period code is 3'b100 (64 ticks by default), and `rst_req`, `ci_set` and `wd_active` are low.
- R2: The period in ticks is `BASE_TICKS << period_code`. With defaults, code 0 gives 4 ticks and code 2 gives 16 ticks.
- R3: In Window mode (`cfg_mode` 2'b01), a trigger is early when the count of ticks since the last restart is below half the period. An early trigger produces `rst_req` in the next cycle.
- R4: In Window mode, when a full period of ticks passes without a trigger, `rst_req` is produced. It appears in the cycle after the tick that completes the period.
- R5: In Window mode, a trigger at a count of at least half the period restarts the counter and produces no output.
- R6: In Timeout mode (`cfg_mode` 2'b10), an overflow with `irq_pending` low produces a one-cycle `ci_set` and restarts the counter.
- R7: In Timeout mode, an overflow with `irq_pending` high produces `rst_req` instead of `ci_set`.
- R8: In Timeout mode, a trigger at any count restarts the counter.
- R9: The watchdog is Off when the stored mode is 2'b00 (a write of 2'b11 is stored as Off) or when `off_pin` is high. While Off, `wd_active` is low, no pulse is produced and the counter is held at zero.
- R10: When the stored mode is Off, `off_pin` is low and `irq_pending` is high, the stored mode becomes Timeout and the counter starts from zero.
- R11: Every reset request returns the period code to 3'b100 and restarts the counter. It keeps the mode. A configuration write in the same cycle is discarded.
- R12: A configuration write that changes the mode or the period code restarts the counter. A write of identical values has no effect.
- R13: `rst_req` and `ci_set` are registered single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable, one cycle per tick |
| trig | input | 1 | Host trigger strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode to write: 00 Off, 01 Window, 10 Timeout, 11 Off |
| cfg_period | input | 3 | Period code to write |
| off_pin | input | 1 | High forces Off mode |
| irq_pending | input | 1 | Cyclic interrupt still pending in the host-visible status |
| rst_req | output | 1 | System reset request pulse |
| ci_set | output | 1 | Cyclic interrupt set pulse |
| wd_active | output | 1 | Watchdog is currently running |

## Verification
`rst_req` and `ci_set` are registered. Each appears one cycle after the clock edge that sees the early trigger or the completing tick. The bench therefore samples them at the falling edge after that rising edge. `wd_active` is combinational from stored mode and `off_pin`, so it is compared in the same half-cycle that the inputs hold.

The bench advances a reference model once per rising edge and compares every output at the following falling edge. Directed cases count the steps from a restart to the first pulse and compare that count with the period restated from the requirements.

// File: rtl/mm_wdog_pkg.sv
package mm_wdog_pkg;

  typedef enum logic [1:0] {
    WD_OFF = 2'b00,
    WD_WIN = 2'b01,
    WD_TMO = 2'b10
  } wd_mode_e;

  localparam logic [2:0] PCODE_HOME = 3'b100;

  // ticks in one watchdog period for a given code
  function automatic int unsigned period_ticks(input int unsigned base, input logic [2:0] code);
    return base << code;
  endfunction

  // encoding 2'b11 is not a mode: store it as Off
  function automatic wd_mode_e norm_mode(input logic [1:0] m);
    case (m)
      2'b01:   return WD_WIN;
      2'b10:   return WD_TMO;
      default: return WD_OFF;
    endcase
  endfunction

endpackage

// File: rtl/wdg_cfg.sv
module wdg_cfg
  import mm_wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_mode,
  input  logic [2:0] cfg_period,
  input  logic       off_pin,
  input  logic       irq_pending,
  input  logic       sys_rst_evt,
  output wd_mode_e   mode_q,
  output logic [2:0] period_q,
  output logic       cfg_change,
  output logic       auto_wake
);

  wd_mode_e wr_mode;

  always_comb begin
    wr_mode    = norm_mode(cfg_mode);
    cfg_change = cfg_we && ((wr_mode != mode_q) || (cfg_period != period_q));
    auto_wake  = (mode_q == WD_OFF) && !off_pin && irq_pending;
  end

  // priority: reset request, then a changing write, then automatic wake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= WD_OFF;
      period_q <= PCODE_HOME;
    end else if (sys_rst_evt) begin
      period_q <= PCODE_HOME;
    end else if (cfg_change) begin
      mode_q   <= wr_mode;
      period_q <= cfg_period;
    end else if (auto_wake) begin
      mode_q   <= WD_TMO;
    end
  end

  a_r11_period_home: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_evt |=> (period_q == PCODE_HOME));

  a_r10_wake_to_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_wake && !sys_rst_evt && !cfg_change) |=> (mode_q == WD_TMO));

  a_r12_write_applied: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_change && !sys_rst_evt) |=> (period_q == $past(cfg_period)));

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt_q,
  output logic          at_last
);

  always_comb at_last = (cnt_q == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (tick)    cnt_q <= at_last ? '0 : cnt_q + CW'(1);
  end

  a_r2_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < limit);

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/wdg_judge.sv
module wdg_judge
  import mm_wdog_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wd_mode_e      eff_mode,
  input  logic          trig,
  input  logic          tick,
  input  logic          irq_pending,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] half,
  input  logic          at_last,
  output logic          rst_evt,
  output logic          rst_req,
  output logic          ci_set
);

  logic early_trig;
  logic overflow;
  logic ci_evt;

  always_comb begin
    early_trig = (eff_mode == WD_WIN) && trig && (cnt < half);
    overflow   = (eff_mode != WD_OFF) && tick && at_last && !trig;
    rst_evt    = early_trig || (overflow && ((eff_mode == WD_WIN) || irq_pending));
    ci_evt     = overflow && (eff_mode == WD_TMO) && !irq_pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      ci_set  <= 1'b0;
    end else begin
      rst_req <= rst_evt;
      ci_set  <= ci_evt;
    end
  end

  a_r13_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && ci_set));

  a_r3_early_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ((eff_mode == WD_WIN) && trig && (cnt < half)) |=> rst_req);

  a_r7_pending_escalates: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && (eff_mode == WD_TMO) && irq_pending) |=> (rst_req && !ci_set));

  a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == WD_OFF) |=> (!rst_req && !ci_set));

endmodule

// File: rtl/mm_watchdog.sv
module mm_watchdog
  import mm_wdog_pkg::*;
#(
  parameter int BASE_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       trig,
  input  logic       cfg_we,
  input  logic [1:0] cfg_mode,
  input  logic [2:0] cfg_period,
  input  logic       off_pin,
  input  logic       irq_pending,
  output logic       rst_req,
  output logic       ci_set,
  output logic       wd_active
);

  localparam int MAX_TICKS = BASE_TICKS << 7;
  localparam int CW        = $clog2(MAX_TICKS + 1);

  wd_mode_e      mode_q;
  wd_mode_e      eff_mode;
  logic [2:0]    period_q;
  logic          cfg_change;
  logic          auto_wake;
  logic          rst_evt;
  logic          cnt_clear;
  logic [CW-1:0] limit;
  logic [CW-1:0] half;
  logic [CW-1:0] cnt;
  logic          at_last;

  always_comb begin
    eff_mode  = off_pin ? WD_OFF : mode_q;
    wd_active = (eff_mode != WD_OFF);
    limit     = CW'(period_ticks(BASE_TICKS, period_q));
    half      = limit >> 1;
    cnt_clear = rst_evt || cfg_change || auto_wake || (eff_mode == WD_OFF) || trig;
  end

  wdg_cfg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_mode    (cfg_mode),
    .cfg_period  (cfg_period),
    .off_pin     (off_pin),
    .irq_pending (irq_pending),
    .sys_rst_evt (rst_evt),
    .mode_q      (mode_q),
    .period_q    (period_q),
    .cfg_change  (cfg_change),
    .auto_wake   (auto_wake)
  );

  wdg_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cnt_clear),
    .tick    (tick),
    .limit   (limit),
    .cnt_q   (cnt),
    .at_last (at_last)
  );

  wdg_judge #(.CW(CW)) u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .eff_mode    (eff_mode),
    .trig        (trig),
    .tick        (tick),
    .irq_pending (irq_pending),
    .cnt         (cnt),
    .half        (half),
    .at_last     (at_last),
    .rst_evt     (rst_evt),
    .rst_req     (rst_req),
    .ci_set      (ci_set)
  );

  a_r9_inactive_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    off_pin |-> !wd_active);

endmodule

// File: tb/mm_watchdog_test.sv
module mm_watchdog_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d_tick = 0, d_trig = 0, d_we = 0, d_off = 0, d_irq = 0;
  logic [1:0] d_mode = 2'b00;
  logic [2:0] d_per = 3'b100;
  logic rst_req, ci_set, wd_active;

  int checks = 0;
  int fails = 0;
  string cur_tag = "R1";

  // reference state
  int m_mode = 0;
  int m_per = 4;
  int m_cnt = 0;
  logic e_rst = 0, e_ci = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_watchdog uut (
    .clk(clk), .rst_n(rst_n), .tick(d_tick), .trig(d_trig), .cfg_we(d_we),
    .cfg_mode(d_mode), .cfg_period(d_per), .off_pin(d_off), .irq_pending(d_irq),
    .rst_req(rst_req), .ci_set(ci_set), .wd_active(wd_active)
  );

  function automatic int ticks_of(input int code);
    int t = 4;
    for (int i = 0; i < code; i++) t = t * 2;
    return t;
  endfunction

  function automatic int mode_of(input logic [1:0] m);
    return (m == 2'b01) ? 1 : (m == 2'b10) ? 2 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int eff, p, nm;
    logic early, ovf, chg, wake;
    eff   = d_off ? 0 : m_mode;
    p     = ticks_of(m_per);
    early = (eff == 1) && d_trig && (m_cnt < p / 2);
    ovf   = (eff != 0) && d_tick && (m_cnt == p - 1) && !d_trig;
    e_rst = early || (ovf && (eff == 1 || d_irq));
    e_ci  = ovf && (eff == 2) && !d_irq;
    nm    = mode_of(d_mode);
    chg   = d_we && (nm != m_mode || int'(d_per) != m_per);
    wake  = (m_mode == 0) && !d_off && d_irq;
    if (e_rst) begin m_per = 4; m_cnt = 0; end
    else if (chg) begin m_mode = nm; m_per = int'(d_per); m_cnt = 0; end
    else if (wake) begin m_mode = 2; m_cnt = 0; end
    else if (eff == 0 || d_trig) m_cnt = 0;
    else if (d_tick) m_cnt = (m_cnt == p - 1) ? 0 : m_cnt + 1;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(cur_tag, int'(rst_req), int'(e_rst), "rst_req");
    chk(cur_tag, int'(ci_set), int'(e_ci), "ci_set");
    chk(cur_tag, int'(wd_active), int'(!d_off && m_mode != 0), "wd_active");
  endtask

  task automatic cfg_write(input logic [1:0] md, input logic [2:0] pc);
    d_mode = md; d_per = pc; d_we = 1;
    step();
    d_we = 0;
  endtask

  task automatic run_for_pulse(input int maxn, output int n, output logic got_rst);
    n = -1; got_rst = 0;
    for (int i = 1; i <= maxn; i++) begin
      step();
      if (rst_req || ci_set) begin n = i; got_rst = rst_req; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, pulses;
    logic gr;
    int unsigned seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_tag = "R1";
    chk("R1", int'(rst_req), 0, "rst_req after reset");
    chk("R1", int'(ci_set), 0, "ci_set after reset");
    chk("R1", int'(wd_active), 0, "wd_active after reset");

    // R1 default period code 100 gives 64 ticks; R6 interrupt on overflow
    d_tick = 1;
    cur_tag = "R6";
    cfg_write(2'b10, 3'b100);
    run_for_pulse(200, n, gr);
    chk("R1", n, 64, "steps to first overflow at home period");
    chk("R6", int'(gr), 0, "overflow kind (0 = interrupt)");

    // R2 period scaling
    cur_tag = "R2";
    cfg_write(2'b10, 3'b000);
    run_for_pulse(50, n, gr);
    chk("R2", n, 4, "steps for code 0");
    cfg_write(2'b10, 3'b010);
    run_for_pulse(50, n, gr);
    chk("R2", n, 16, "steps for code 2");

    // R7 pending interrupt escalates, R11 period returns home
    cur_tag = "R7";
    d_irq = 1;
    cfg_write(2'b10, 3'b000);
    run_for_pulse(50, n, gr);
    chk("R7", n, 4, "steps to escalation");
    chk("R7", int'(gr), 1, "overflow kind (1 = reset)");
    cur_tag = "R11";
    run_for_pulse(200, n, gr);
    chk("R11", n, 64, "steps after reset request (home period, mode kept)");
    chk("R11", int'(gr), 1, "still timeout with pending irq");
    d_irq = 0;

    // R3 early trigger in window mode
    cur_tag = "R3";
    cfg_write(2'b01, 3'b011);
    repeat (5) step();
    d_trig = 1; step(); d_trig = 0;
    chk("R3", int'(rst_req), 1, "early trigger reset");

    // R5 valid trigger, R4 missed trigger
    cur_tag = "R5";
    cfg_write(2'b01, 3'b011);
    repeat (20) step();
    d_trig = 1; step(); d_trig = 0;
    chk("R5", int'(rst_req), 0, "late-half trigger accepted");
    cur_tag = "R4";
    run_for_pulse(100, n, gr);
    chk("R4", n, 32, "steps to missed-trigger reset");
    chk("R4", int'(gr), 1, "missed trigger kind");

    // R8 triggers at any count keep timeout quiet
    cur_tag = "R8";
    cfg_write(2'b10, 3'b000);
    pulses = 0;
    for (int k = 0; k < 10; k++) begin
      repeat (3) begin step(); pulses += int'(rst_req | ci_set); end
      d_trig = 1; step(); d_trig = 0; pulses += int'(rst_req | ci_set);
    end
    chk("R8", pulses, 0, "pulses while triggered");
    run_for_pulse(20, n, gr);
    chk("R8", n, 4, "overflow after last trigger");

    // R9 off via code 11 and via off pin
    cur_tag = "R9";
    cfg_write(2'b11, 3'b000);
    pulses = 0;
    repeat (50) begin step(); pulses += int'(rst_req | ci_set | wd_active); end
    chk("R9", pulses, 0, "activity with mode code 11");
    cfg_write(2'b01, 3'b000);
    d_off = 1; d_irq = 1;
    pulses = 0;
    repeat (50) begin step(); pulses += int'(rst_req | ci_set | wd_active); end
    chk("R9", pulses, 0, "activity with off pin high");
    d_off = 0; d_irq = 0;

    // R10 automatic wake from Off
    cur_tag = "R10";
    cfg_write(2'b00, 3'b000);
    step();
    d_irq = 1; step(); d_irq = 0;
    chk("R10", int'(wd_active), 1, "active after wake");
    run_for_pulse(20, n, gr);
    chk("R10", n, 4, "steps to interrupt after wake");
    chk("R10", int'(gr), 0, "woke into timeout");

    // R12 identical write ignored, changing write restarts
    cur_tag = "R12";
    cfg_write(2'b10, 3'b010);
    repeat (10) step();
    cfg_write(2'b10, 3'b010);
    run_for_pulse(30, n, gr);
    chk("R12", n, 5, "identical write left counter running");
    repeat (3) step();
    cfg_write(2'b10, 3'b001);
    run_for_pulse(30, n, gr);
    chk("R12", n, 8, "changing write restarted counter");

    // random mix, every cycle compared with the reference (R13 pulses)
    cur_tag = "R13";
    for (int i = 0; i < 3000; i++) begin
      d_tick = ($urandom % 4) != 0;
      d_trig = ($urandom % 9) == 0;
      d_we   = ($urandom % 40) == 0;
      d_mode = 2'($urandom % 4);
      d_per  = 3'($urandom % 3);
      d_off  = ($urandom % 50) == 0;
      d_irq  = ($urandom % 3) == 0;
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule